// File: doc/BRIEF.md
# SHA-1 Block Compression Engine

This engine applies the SHA-1 compression function to one 512-bit message block and produces the updated 160-bit chaining value. The caller feeds the block in as sixteen 32-bit words, most significant word first. It does this by holding a load strobe high on consecutive clocks while the engine is idle. A one-cycle start pulse then launches the computation. The 80 rounds run one per clock. The five working variables are then added word-wise to the chaining value, and the sum is registered as the digest.

Each start pulse selects the chaining value to use. The value can come from the 160-bit external input, such as the standard initial value 67452301 EFCDAB89 98BADCFE 10325476 C3D2E1F0 packed with its first word in the top bits. It can also come from the digest the engine produced last, so that the blocks of a long message can be processed back to back without routing the digest outside. Padding, length encoding and splitting a message into blocks are left to the caller.

Top module: `sha1_block_engine`

## Requirements
- R1: With `load_en` high on a clock while idle, `load_word` is appended to the block; sixteen such words, the first loaded being bits 511:480 of the block, form the block compressed on the next start.
- R2: A start pulse sampled while idle sets `busy` on the following clock edge.
- R3: `busy` stays high for exactly 81 clock cycles per block (80 rounds plus one cycle for the final addition).
- R4: `out_valid` is high for exactly one cycle, the first cycle in which `busy` is low again, and is never high while `busy` is high.
- R5: With `chain_sel` high at start, the chaining value is the engine's own current digest instead of `cv_in`.
- R6: With `chain_sel` low at start, the chaining value is `cv_in`, bits 159:128 being the first chaining word; the digest equals the SHA-1 compression of the loaded block with that value, packed the same way.
- R7: The block holding the padded message "abc" with the standard initial value yields a9993e36 4706816a ba3e2571 7850c26c 9cd0d89d.
- R8: The two padded blocks of the 448-bit string "abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq", with the second block chained, yield 84983e44 1c3bd26e baae4aa1 f95129e5 e54670f1.
- R9: After a synchronous reset `busy` and `out_valid` are low and the digest is zero, so a chained start straight after reset uses an all-zero chaining value.
- R10: A start pulse that arrives while `busy` is high is ignored: the running block finishes with its correct digest after the normal 81 busy cycles.
- R11: `load_en` pulses while `busy` is high are ignored and do not disturb the running computation.
- R12: The controller state is encoded 2'b01 while rounds execute, and the round counter steps by one per clock from 0 to 79.
- R13: The digest output changes only in the cycle in which `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that launches a compression |
| chain_sel | input | 1 | At start: 1 = chain from the previous digest, 0 = use `cv_in` |
| load_en | input | 1 | Word load strobe, honoured only while idle |
| load_word | input | 32 | Block word, most significant word first |
| cv_in | input | 160 | External chaining value, first word in bits 159:128 |
| busy | output | 1 | High while a block is being compressed |
| out_valid | output | 1 | One-cycle pulse when a new digest is presented |
| digest | output | 160 | Registered result, first word in bits 159:128 |

## Verification
The embedded assertions check on every cycle that a start from idle raises busy, that the busy window lasts exactly 81 cycles, and that the valid pulse is a single cycle at the falling edge of busy. They also check that the digest moves only with that pulse, that loads are never accepted during a run, and that the round counter steps cleanly through the running state. The digest values themselves can only be shown by the bench's scenarios. These scenarios cover the two standard vectors, random blocks and chaining values compared with a bench-side model, chaining straight from reset, and start and load pulses injected in the middle of a run.

// File: rtl/sha1_eng_pkg.sv
package sha1_eng_pkg;

  localparam int WORD_W      = 32;
  localparam int BLOCK_WORDS = 16;
  localparam int ROUNDS      = 80;
  localparam int STAGE_LEN   = 20;
  localparam int VARS        = 5;
  localparam int RND_W       = $clog2(ROUNDS);

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RUN  = 2'b01,
    ST_FOLD = 2'b10
  } eng_state_t;

  typedef struct packed {
    word_t a;
    word_t b;
    word_t c;
    word_t d;
    word_t e;
  } vars_t;

  function automatic word_t rol(input word_t x, input int n);
    return (x << n) | (x >> (WORD_W - n));
  endfunction

  function automatic logic [1:0] stage_of(input logic [RND_W-1:0] rnd);
    if (rnd < RND_W'(STAGE_LEN))          return 2'd0;
    else if (rnd < RND_W'(2 * STAGE_LEN)) return 2'd1;
    else if (rnd < RND_W'(3 * STAGE_LEN)) return 2'd2;
    else                                  return 2'd3;
  endfunction

  function automatic word_t mix_fn(input logic [1:0] stg, input word_t b,
                                   input word_t c, input word_t d);
    case (stg)
      2'd0:    return (b & c) | (~b & d);
      2'd2:    return (b & c) | (b & d) | (c & d);
      default: return b ^ c ^ d;
    endcase
  endfunction

  function automatic word_t stage_const(input logic [1:0] stg);
    case (stg)
      2'd0:    return 32'h5A827999;
      2'd1:    return 32'h6ED9EBA1;
      2'd2:    return 32'h8F1BBCDC;
      default: return 32'hCA62C1D6;
    endcase
  endfunction

endpackage

// File: rtl/sha1_eng_ctrl.sv
module sha1_eng_ctrl
  import sha1_eng_pkg::*;
#(
  parameter int N_ROUNDS = ROUNDS
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  output eng_state_t       state_o,
  output logic [RND_W-1:0] rnd_o,
  output logic             launch_o,
  output logic             step_o,
  output logic             fold_o
);

  localparam logic [RND_W-1:0] LAST_RND = RND_W'(N_ROUNDS - 1);

  eng_state_t       state_q;
  logic [RND_W-1:0] rnd_q;

  assign launch_o = (state_q == ST_IDLE) && start_i;
  assign step_o   = (state_q == ST_RUN);
  assign fold_o   = (state_q == ST_FOLD);
  assign state_o  = state_q;
  assign rnd_o    = rnd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      rnd_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          rnd_q <= '0;
          if (start_i) state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (rnd_q == LAST_RND) begin
            state_q <= ST_FOLD;
            rnd_q   <= '0;
          end else begin
            rnd_q <= rnd_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R12: counter never leaves 0..79 while running
  p_round_limit_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (rnd_q <= LAST_RND));

  // R12 / R10: running counter steps by one, a start pulse cannot restart it
  p_round_step_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && rnd_q != LAST_RND) |=>
      (state_q == ST_RUN && rnd_q == $past(rnd_q) + 1'b1));

  // R12: last round is followed by the fold cycle
  p_run_to_fold_r12: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN && rnd_q == LAST_RND) |=> (state_q == ST_FOLD));

  // R10: start outside idle is ignored
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_FOLD) |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sha1_eng_sched.sv
module sha1_eng_sched
  import sha1_eng_pkg::*;
#(
  parameter int DEPTH = BLOCK_WORDS
) (
  input  logic  clk,
  input  logic  load_i,
  input  word_t load_word_i,
  input  logic  shift_i,
  output word_t w_o
);

  // Taps for the word sixteen places ahead of the head: t+13, t+8, t+2, t
  localparam int TAP_A = DEPTH - 3;
  localparam int TAP_B = DEPTH - 8;
  localparam int TAP_C = DEPTH - 14;

  word_t win_q [DEPTH];
  word_t next_word;
  word_t tail_in;

  assign next_word = rol(win_q[TAP_A] ^ win_q[TAP_B] ^ win_q[TAP_C] ^ win_q[0], 1);
  assign tail_in   = load_i ? load_word_i : next_word;
  assign w_o       = win_q[0];

  generate
    for (genvar i = 0; i < DEPTH - 1; i++) begin : g_win
      always_ff @(posedge clk) begin
        if (load_i || shift_i) win_q[i] <= win_q[i+1];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (load_i || shift_i) win_q[DEPTH-1] <= tail_in;
  end

  // R11: window is never loaded and advanced in the same cycle
  p_load_vs_shift_r11: assert property (@(posedge clk)
    !(load_i && shift_i));

endmodule

// File: rtl/sha1_eng_round.sv
module sha1_eng_round
  import sha1_eng_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  vars_t            init_vars_i,
  input  logic             step_i,
  input  logic [RND_W-1:0] rnd_i,
  input  word_t            w_i,
  output vars_t            vars_o
);

  vars_t      v_q;
  vars_t      v_next;
  logic [1:0] stg;
  word_t      f_val;
  word_t      k_val;
  word_t      t_val;

  always_comb begin
    stg    = stage_of(rnd_i);
    f_val  = mix_fn(stg, v_q.b, v_q.c, v_q.d);
    k_val  = stage_const(stg);
    t_val  = rol(v_q.a, 5) + f_val + v_q.e + k_val + w_i;
    v_next = '{a: t_val, b: v_q.a, c: rol(v_q.b, 30), d: v_q.c, e: v_q.d};
  end

  always_ff @(posedge clk) begin
    if (rst)         v_q <= '0;
    else if (init_i) v_q <= init_vars_i;
    else if (step_i) v_q <= v_next;
  end

  assign vars_o = v_q;

  // R12: a round shifts the variable chain b<-a, d<-c, e<-d
  p_var_shift_r12: assert property (@(posedge clk) disable iff (rst)
    (step_i && !init_i) |=>
      (v_q.b == $past(v_q.a) && v_q.d == $past(v_q.c) && v_q.e == $past(v_q.d)));

endmodule

// File: rtl/sha1_block_engine.sv
module sha1_block_engine
  import sha1_eng_pkg::*;
#(
  parameter int N_ROUNDS = ROUNDS,
  parameter int N_WORDS  = BLOCK_WORDS,
  parameter int W        = WORD_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic           chain_sel,
  input  logic           load_en,
  input  logic [W-1:0]   load_word,
  input  logic [5*W-1:0] cv_in,
  output logic           busy,
  output logic           out_valid,
  output logic [5*W-1:0] digest
);

  localparam int BUSY_CYCLES = N_ROUNDS + 1;
  localparam int CNT_W       = $clog2(BUSY_CYCLES + 1) + 1;

  eng_state_t       state;
  logic [RND_W-1:0] rnd;
  logic             launch;
  logic             step;
  logic             fold;
  logic             load_ok;
  word_t            w_cur;
  vars_t            cv_q;
  vars_t            cv_sel;
  vars_t            vars;
  vars_t            result_q;
  logic             valid_q;

  sha1_eng_ctrl #(.N_ROUNDS(N_ROUNDS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start),
    .state_o  (state),
    .rnd_o    (rnd),
    .launch_o (launch),
    .step_o   (step),
    .fold_o   (fold)
  );

  assign load_ok = load_en && (state == ST_IDLE);

  sha1_eng_sched #(.DEPTH(N_WORDS)) u_sched (
    .clk         (clk),
    .load_i      (load_ok),
    .load_word_i (load_word),
    .shift_i     (step),
    .w_o         (w_cur)
  );

  assign cv_sel = chain_sel ? result_q : vars_t'(cv_in);

  sha1_eng_round u_round (
    .clk         (clk),
    .rst         (rst),
    .init_i      (launch),
    .init_vars_i (cv_sel),
    .step_i      (step),
    .rnd_i       (rnd),
    .w_i         (w_cur),
    .vars_o      (vars)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cv_q     <= '0;
      result_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= fold;
      if (launch) cv_q <= cv_sel;
      if (fold) begin
        result_q.a <= cv_q.a + vars.a;
        result_q.b <= cv_q.b + vars.b;
        result_q.c <= cv_q.c + vars.c;
        result_q.d <= cv_q.d + vars.d;
        result_q.e <= cv_q.e + vars.e;
      end
    end
  end

  assign busy      = (state != ST_IDLE);
  assign out_valid = valid_q;
  assign digest    = result_q;

  // Busy window length tracker for R3
  logic [CNT_W-1:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst || !busy) busy_len <= '0;
    else              busy_len <= busy_len + 1'b1;
  end

  p_busy_rise_r2: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  p_busy_len_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_len == CNT_W'(BUSY_CYCLES)));

  p_valid_edge_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (!busy && $past(busy)));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_no_load_busy_r11: assert property (@(posedge clk) disable iff (rst)
    load_ok |-> !busy);

  p_digest_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !out_valid |=> (out_valid || $stable(digest)));

endmodule

// File: tb/tb_sha1_block_engine.sv
module tb_sha1_block_engine;

  localparam logic [159:0] IV = 160'h67452301EFCDAB8998BADCFE10325476C3D2E1F0;

  logic         clk = 1'b0;
  logic         rst;
  logic         start;
  logic         chain_sel;
  logic         load_en;
  logic [31:0]  load_word;
  logic [159:0] cv_in;
  logic         busy;
  logic         out_valid;
  logic [159:0] digest;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  sha1_block_engine dut (
    .clk(clk), .rst(rst), .start(start), .chain_sel(chain_sel),
    .load_en(load_en), .load_word(load_word), .cv_in(cv_in),
    .busy(busy), .out_valid(out_valid), .digest(digest)
  );

  function automatic logic [31:0] rl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [159:0] ref_compress(input logic [511:0] blk,
                                                input logic [159:0] h);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = blk[511 - 32*i -: 32];
    for (int i = 16; i < 80; i++) w[i] = rl(w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16], 1);
    {a, b, c, d, e} = h;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = rl(a, 5) + f + e + k + w[i];
      e = d; d = c; c = rl(b, 30); b = a; a = t;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  task automatic check(input bit ok, input string req, input logic [159:0] act,
                       input logic [159:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_block(input logic [511:0] blk);
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      load_en   = 1'b1;
      load_word = blk[511 - 32*i -: 32];
    end
    @(negedge clk);
    load_en = 1'b0;
  endtask

  // Starts a block, optionally injecting a start pulse (R10) and load strobes (R11) mid-run
  task automatic run_block(input logic [159:0] cv, input bit chain,
                           input logic [159:0] exp, input string req,
                           input bit poke_start, input bit poke_load);
    int  n;
    bit  vbad;
    start     = 1'b1;
    chain_sel = chain;
    cv_in     = cv;
    @(negedge clk);
    start     = 1'b0;
    chain_sel = 1'b0;
    cv_in     = $urandom;
    check(busy == 1'b1, "R2 busy after start", 160'(busy), 160'd1);
    n = 0; vbad = 1'b0;
    while (busy && n < 200) begin
      if (out_valid) vbad = 1'b1;
      n++;
      start     = poke_start && (n == 20);
      chain_sel = poke_start && (n == 20);
      load_en   = poke_load && (n >= 30 && n < 34);
      load_word = $urandom;
      @(negedge clk);
    end
    start = 1'b0; load_en = 1'b0; chain_sel = 1'b0;
    check(n == 81, "R3 busy length", 160'(n), 160'd81);
    check(out_valid && !vbad, "R4 valid at busy fall", 160'(out_valid), 160'd1);
    check(digest == exp, req, digest, exp);
    @(negedge clk);
    check(!out_valid && digest == exp, "R4/R13 pulse ends, digest held",
          {159'(digest[158:0]), out_valid}, {159'(exp[158:0]), 1'b0});
  endtask

  initial begin
    logic [511:0] blk;
    logic [159:0] cv, exp, prev;
    void'($urandom(32'd20240611));
    rst = 1'b1; start = 1'b0; chain_sel = 1'b0; load_en = 1'b0;
    load_word = '0; cv_in = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy, "R9 busy after reset", 160'(busy), 160'd0);
    check(!out_valid, "R9 valid after reset", 160'(out_valid), 160'd0);
    check(digest == '0, "R9 digest after reset", digest, 160'd0);

    // R9/R5: chained start straight after reset uses zero chaining value
    blk = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
           $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
    load_block(blk);
    run_block(IV, 1'b1, ref_compress(blk, 160'd0), "R9 chain from reset", 1'b0, 1'b0);

    // R7 / R1 / R6
    blk = {"abc", 8'h80, 416'd0, 64'd24};
    load_block(blk);
    run_block(IV, 1'b0, 160'ha9993e364706816aba3e25717850c26c9cd0d89d, "R7 abc digest",
              1'b0, 1'b0);

    // R8 / R5: two-block message, second chained
    blk = {"abcdbcdecdefdefgefghfghighijhijkijkljklmklmnlmnomnopnopq", 8'h80, 56'd0};
    load_block(blk);
    run_block(IV, 1'b0, ref_compress(blk, IV), "R8 first block", 1'b0, 1'b0);
    load_block({448'd0, 64'd448});
    run_block(IV ^ 160'h1, 1'b1, 160'h84983e441c3bd26ebaae4aa1f95129e5e54670f1,
              "R8 two-block digest", 1'b0, 1'b0);

    // R6 / R5: random blocks, random external values, random chaining
    for (int r = 0; r < 6; r++) begin
      bit ch;
      blk = {$urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
             $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom};
      cv   = {$urandom, $urandom, $urandom, $urandom, $urandom};
      ch   = ($urandom % 2) == 1;
      prev = digest;
      exp  = ref_compress(blk, ch ? prev : cv);
      load_block(blk);
      run_block(cv, ch, exp, ch ? "R5 random chained" : "R6 random external", 1'b0, 1'b0);
    end

    // R1: all-ones and alternating patterns
    blk = {16{32'hFFFFFFFF}};
    load_block(blk);
    run_block(IV, 1'b0, ref_compress(blk, IV), "R1 all-ones block", 1'b0, 1'b0);
    blk = {8{32'hAAAAAAAA, 32'h55555555}};
    load_block(blk);
    run_block(IV, 1'b0, ref_compress(blk, IV), "R1 alternating block", 1'b0, 1'b0);

    // R10: start pulse mid-run ignored
    blk = {"abc", 8'h80, 416'd0, 64'd24};
    load_block(blk);
    run_block(IV, 1'b0, 160'ha9993e364706816aba3e25717850c26c9cd0d89d,
              "R10 start during busy ignored", 1'b1, 1'b0);

    // R11: load strobes mid-run ignored
    load_block(blk);
    run_block(IV, 1'b0, 160'ha9993e364706816aba3e25717850c26c9cd0d89d,
              "R11 load during busy ignored", 1'b0, 1'b1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule